// File: doc/BRIEF.md
# SIMD Shift and Bit-Field Execution Unit

This block is a 32-bit execution unit for a DSP datapath. It handles three classes of operation. The first class is shifts. The second is bit-field work: extracting a field, or depositing a field into a word. The third is halfword and byte packing and unpacking. Shifts and bit-field operations can run on the full word. They can also run as two independent 16-bit lanes, selected by a SIMD flag. The pack class ignores that flag.

Shifts and bit-field operations go through one shared barrel shifter, which has no separate copy for field work. Operand isolation forces the inputs of the shifter path and the pack path to zero whenever their class is not the selected one. Each accepted operation produces a registered result one clock later, together with a matching valid flag.

Top module: `simd_bitop_unit`

## Requirements
- R1: `out_valid` equals the value `in_valid` had at the previous rising clock edge. An operation accepted at an edge shows its result on `out_result` right after the next edge, giving a one-cycle latency.
- R2: After reset, `out_valid` and `out_result` are zero. While `in_valid` is low, `out_result` keeps its previous value.
- R3: In 32-bit mode (`in_simd`=0), opcode 0 is a logical left shift, opcode 1 a logical right shift and opcode 2 an arithmetic right shift of `in_a`. The shift amount is `in_b[4:0]`, and all other bits of `in_b` are ignored.
- R4: In SIMD mode (`in_simd`=1), opcodes 0 to 2 shift each 16-bit lane of `in_a` on its own. The low lane uses `in_b[3:0]` and the high lane uses `in_b[19:16]`. No bit crosses between bit 15 and bit 16. An arithmetic shift fills the low lane from bit 15 and the high lane from bit 31.
- R5: Opcode 3 in 32-bit mode is field extract. The start is p = `in_b[4:0]` and the length is n = `in_b[9:5]`+1. Result bit i equals `in_a[i+p]` when i < n and i+p < 32, and is 0 otherwise.
- R6: Opcode 3 in SIMD mode extracts per lane. Each lane reads a control byte at its own lane offset in `in_b` (bits 7:0 for the low lane, bits 23:16 for the high lane). The low nibble of that byte is the start and the high nibble is the length minus 1. Bits past the end of a lane read as 0.
- R7: Opcode 4 in 32-bit mode is field deposit. The field value is `in_b[31:16]`, zero-extended. The start is `in_b[4:0]` and the length is `in_b[9:5]`+1. Result bits from start to start+length-1 take the field, and all other bits come from `in_a`. Any part of the window above bit 31 is dropped.
- R8: Opcode 4 in SIMD mode deposits per lane, using the same control byte layout as R6. The field value is `in_b[15:8]` for the low lane and `in_b[31:24]` for the high lane, zero-extended to 16 bits. The window is cut off at the lane top.
- R9: Opcode 5 packs two halfwords into `{in_b[15:0], in_a[15:0]}`, whatever the value of `in_simd`.
- R10: The unpack opcodes all read `in_a`. Opcodes 6 and 7 sign-extend and zero-extend `in_a[15:0]`. Opcodes 8 and 9 do the same for `in_a[31:16]`. Opcodes 10 and 11 do the same for `in_a[7:0]`. The SIMD flag is ignored.
- R11: Opcodes 12 to 15 produce a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 4 | Opcode |
| in_simd | input | 1 | 1 selects two 16-bit lanes |
| in_a | input | 32 | Data operand |
| in_b | input | 32 | Amount, control fields, field value or second halfword |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 32 | Registered result |

## Verification
The only state in the block is the output register and the valid flag, so any fault reaches the ports within one clock. A wrong shift amount, a mask that leaks across lanes or a bad isolation gate shows up as a mismatch in the cycle right after the affected operation. A register that updates while `in_valid` is low shows up on the next idle cycle as a change in a value that should have held. The reference model is compared against the outputs on every clock, so the cycle and the opcode of the first divergence point straight at the faulty path.

// File: rtl/sbu_pkg.sv
package sbu_pkg;

    parameter int unsigned XW  = 32;
    localparam int unsigned HW  = XW / 2;
    localparam int unsigned AW  = $clog2(XW);
    localparam int unsigned HAW = $clog2(HW);
    localparam int unsigned BW  = HW / 2;

    typedef enum logic [3:0] {
        OP_SLL    = 4'd0,
        OP_SRL    = 4'd1,
        OP_SRA    = 4'd2,
        OP_XTR    = 4'd3,
        OP_DEP    = 4'd4,
        OP_PAIR   = 4'd5,
        OP_EXH_LS = 4'd6,
        OP_EXH_LZ = 4'd7,
        OP_EXH_HS = 4'd8,
        OP_EXH_HZ = 4'd9,
        OP_EXB_S  = 4'd10,
        OP_EXB_Z  = 4'd11
    } sbu_op_e;

    typedef enum logic [1:0] {
        CL_NONE  = 2'd0,
        CL_SHIFT = 2'd1,
        CL_FIELD = 2'd2,
        CL_PACK  = 2'd3
    } sbu_class_e;

    typedef struct packed {
        sbu_class_e cls;
        logic       left;
        logic       arith;
        logic       dep;
    } sbu_ctl_t;

    function automatic sbu_ctl_t sbu_decode(input logic [3:0] op);
        sbu_ctl_t c;
        c = '{cls: CL_NONE, left: 1'b0, arith: 1'b0, dep: 1'b0};
        case (op)
            OP_SLL: begin c.cls = CL_SHIFT; c.left = 1'b1; end
            OP_SRL: c.cls = CL_SHIFT;
            OP_SRA: begin c.cls = CL_SHIFT; c.arith = 1'b1; end
            OP_XTR: c.cls = CL_FIELD;
            OP_DEP: begin c.cls = CL_FIELD; c.left = 1'b1; c.dep = 1'b1; end
            OP_PAIR, OP_EXH_LS, OP_EXH_LZ, OP_EXH_HS,
            OP_EXH_HZ, OP_EXB_S, OP_EXB_Z: c.cls = CL_PACK;
            default: c.cls = CL_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sbu_shifter.sv
module sbu_shifter
    import sbu_pkg::*;
(
    input  logic [XW-1:0]  sh_d,
    input  logic [AW-1:0]  sh_amt_lo,
    input  logic [HAW-1:0] sh_amt_hi,
    input  logic           sh_left,
    input  logic           sh_arith,
    input  logic           sh_simd,
    output logic [XW-1:0]  sh_q
);

    logic [XW-1:0] full_q;
    logic [HW-1:0] lane_q [2];

    // whole-word path
    always_comb begin
        if (sh_left)
            full_q = sh_d << sh_amt_lo;
        else if (sh_arith)
            full_q = XW'($signed(sh_d) >>> sh_amt_lo);
        else
            full_q = sh_d >> sh_amt_lo;
    end

    // per-lane path: each lane sees only its own bits
    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
        logic [HW-1:0]  ld;
        logic [HAW-1:0] la;
        assign ld = sh_d[ln*HW +: HW];
        assign la = (ln == 0) ? sh_amt_lo[HAW-1:0] : sh_amt_hi;
        always_comb begin
            if (sh_left)
                lane_q[ln] = ld << la;
            else if (sh_arith)
                lane_q[ln] = HW'($signed(ld) >>> la);
            else
                lane_q[ln] = ld >> la;
        end
    end

    assign sh_q = sh_simd ? {lane_q[1], lane_q[0]} : full_q;

endmodule

// File: rtl/sbu_mask.sv
module sbu_mask
    import sbu_pkg::*;
(
    input  logic           mk_simd,
    input  logic           mk_window,
    input  logic [AW-1:0]  mk_pos_full,
    input  logic [AW:0]    mk_len_full,
    input  logic [HAW-1:0] mk_pos_lo,
    input  logic [HAW:0]   mk_len_lo,
    input  logic [HAW-1:0] mk_pos_hi,
    input  logic [HAW:0]   mk_len_hi,
    output logic [XW-1:0]  mk_q
);

    localparam int unsigned CW = AW + 2;

    for (genvar i = 0; i < XW; i++) begin : g_bit
        localparam int unsigned LI   = i % HW;
        localparam int unsigned LANE = i / HW;
        logic [CW-1:0] st, ln, ix;
        always_comb begin
            if (mk_simd) begin
                ix = CW'(LI);
                st = mk_window ? CW'((LANE == 0) ? mk_pos_lo : mk_pos_hi) : '0;
                ln = CW'((LANE == 0) ? mk_len_lo : mk_len_hi);
            end else begin
                ix = CW'(i);
                st = mk_window ? CW'(mk_pos_full) : '0;
                ln = CW'(mk_len_full);
            end
            mk_q[i] = (ix >= st) && (ix < st + ln);
        end
    end

endmodule

// File: rtl/sbu_pack.sv
module sbu_pack
    import sbu_pkg::*;
(
    input  logic [3:0]    pk_op,
    input  logic [XW-1:0] pk_a,
    input  logic [XW-1:0] pk_b,
    output logic [XW-1:0] pk_q
);

    always_comb begin
        case (pk_op)
            OP_PAIR:   pk_q = {pk_b[HW-1:0], pk_a[HW-1:0]};
            OP_EXH_LS: pk_q = {{HW{pk_a[HW-1]}}, pk_a[HW-1:0]};
            OP_EXH_LZ: pk_q = {{HW{1'b0}}, pk_a[HW-1:0]};
            OP_EXH_HS: pk_q = {{HW{pk_a[XW-1]}}, pk_a[XW-1:HW]};
            OP_EXH_HZ: pk_q = {{HW{1'b0}}, pk_a[XW-1:HW]};
            OP_EXB_S:  pk_q = {{(XW-BW){pk_a[BW-1]}}, pk_a[BW-1:0]};
            OP_EXB_Z:  pk_q = {{(XW-BW){1'b0}}, pk_a[BW-1:0]};
            default:   pk_q = '0;
        endcase
    end

endmodule

// File: rtl/simd_bitop_unit.sv
module simd_bitop_unit
    import sbu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    in_op,
    input  logic          in_simd,
    input  logic [XW-1:0] in_a,
    input  logic [XW-1:0] in_b,
    output logic          out_valid,
    output logic [XW-1:0] out_result
);

    sbu_ctl_t      ctl;
    logic          use_sh, use_pk;
    logic [XW-1:0] sh_a, sh_b, pk_a, pk_b;
    logic [XW-1:0] fld_val, sh_in, sh_q, mask_q, pk_q, nxt;
    logic          iso_simd;

    assign ctl    = sbu_decode(in_op);
    assign use_sh = (ctl.cls == CL_SHIFT) || (ctl.cls == CL_FIELD);
    assign use_pk = (ctl.cls == CL_PACK);

    // operand isolation: idle sub-paths see constant zero
    assign sh_a     = use_sh ? in_a : '0;
    assign sh_b     = use_sh ? in_b : '0;
    assign iso_simd = use_sh & in_simd;
    assign pk_a     = use_pk ? in_a : '0;
    assign pk_b     = use_pk ? in_b : '0;

    // deposit value: upper half in word mode, upper byte of each lane in SIMD mode
    assign fld_val = iso_simd
        ? {{BW{1'b0}}, sh_b[XW-1 -: BW], {BW{1'b0}}, sh_b[HW-1 -: BW]}
        : {{HW{1'b0}}, sh_b[XW-1 -: HW]};

    assign sh_in = ctl.dep ? fld_val : sh_a;

    sbu_shifter u_shift (
        .sh_d      (sh_in),
        .sh_amt_lo (sh_b[AW-1:0]),
        .sh_amt_hi (sh_b[HW +: HAW]),
        .sh_left   (ctl.left),
        .sh_arith  (ctl.arith),
        .sh_simd   (iso_simd),
        .sh_q      (sh_q)
    );

    sbu_mask u_mask (
        .mk_simd     (iso_simd),
        .mk_window   (ctl.dep),
        .mk_pos_full (sh_b[AW-1:0]),
        .mk_len_full ({1'b0, sh_b[AW +: AW]} + 1'b1),
        .mk_pos_lo   (sh_b[HAW-1:0]),
        .mk_len_lo   ({1'b0, sh_b[HAW +: HAW]} + 1'b1),
        .mk_pos_hi   (sh_b[HW +: HAW]),
        .mk_len_hi   ({1'b0, sh_b[HW+HAW +: HAW]} + 1'b1),
        .mk_q        (mask_q)
    );

    sbu_pack u_pack (
        .pk_op (in_op),
        .pk_a  (pk_a),
        .pk_b  (pk_b),
        .pk_q  (pk_q)
    );

    always_comb begin
        unique case (ctl.cls)
            CL_SHIFT: nxt = sh_q;
            CL_FIELD: nxt = ctl.dep ? ((sh_a & ~mask_q) | (sh_q & mask_q))
                                    : (sh_q & mask_q);
            CL_PACK:  nxt = pk_q;
            CL_NONE:  nxt = '0;
            default:  nxt = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_result <= nxt;
        end
    end

endmodule

// File: rtl/simd_bitop_unit_chk.sv
module simd_bitop_unit_chk
    import sbu_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [3:0]    in_op,
    input logic          in_simd,
    input logic [XW-1:0] in_a,
    input logic [XW-1:0] in_b,
    input logic          out_valid,
    input logic [XW-1:0] out_result
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result)); // R2
    AST_ZERO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd0 && !in_simd && in_b[4:0] == 5'd0)
        |=> out_result == $past(in_a)); // R3
    AST_LANE_WALL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_simd && in_op == 4'd0 && in_a[15:0] == 16'h0)
        |=> out_result[15:0] == 16'h0); // R4
    AST_PACK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd5)
        |=> out_result == {$past(in_b[15:0]), $past(in_a[15:0])}); // R9
    AST_UNPACK_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == 4'd7 || in_op == 4'd9))
        |=> out_result[31:16] == 16'h0); // R10
    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op >= 4'd12) |=> out_result == '0); // R11

endmodule

bind simd_bitop_unit simd_bitop_unit_chk chk_i (.*);

// File: tb/simd_bitop_unit_tb_top.sv
`timescale 1ns/1ps
module simd_bitop_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic        in_simd = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_result;

    int          n_chk = 0;
    int          n_bad = 0;
    logic        exp_v = 1'b0;
    logic [31:0] exp_r = '0;
    string       exp_tag = "R2";

    always #10 clk = ~clk;

    simd_bitop_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_simd(in_simd), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [31:0] ref_model(input logic [3:0] op, input logic simd,
                                              input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        logic [31:0] f;
        int w, base, amt, len, nl;
        r = '0;
        if (op <= 4) begin
            w  = simd ? 16 : 32;
            nl = simd ? 2 : 1;
            for (int ln = 0; ln < nl; ln++) begin
                base = ln * w;
                if (simd) begin
                    amt = int'(b[base +: 4]);
                    len = int'(b[base + 4 +: 4]) + 1;
                    f   = {24'h0, b[base + 8 +: 8]};
                end else begin
                    amt = int'(b[4:0]);
                    len = int'(b[9:5]) + 1;
                    f   = {16'h0, b[31:16]};
                end
                for (int i = 0; i < w; i++) begin
                    case (op)
                        4'd0: r[base+i] = (i >= amt) ? a[base+i-amt] : 1'b0;
                        4'd1: r[base+i] = (i + amt < w) ? a[base+i+amt] : 1'b0;
                        4'd2: r[base+i] = (i + amt < w) ? a[base+i+amt] : a[base+w-1];
                        4'd3: r[base+i] = (i < len && i + amt < w) ? a[base+i+amt] : 1'b0;
                        default: r[base+i] = (i >= amt && i < amt + len) ? f[i-amt] : a[base+i];
                    endcase
                end
            end
        end else begin
            case (op)
                4'd5:  r = {b[15:0], a[15:0]};
                4'd6:  r = {{16{a[15]}}, a[15:0]};
                4'd7:  r = {16'h0, a[15:0]};
                4'd8:  r = {{16{a[31]}}, a[31:16]};
                4'd9:  r = {16'h0, a[31:16]};
                4'd10: r = {{24{a[7]}}, a[7:0]};
                4'd11: r = {24'h0, a[7:0]};
                default: r = '0;
            endcase
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic simd);
        if (op <= 2)   return simd ? "R4" : "R3";
        if (op == 3)   return simd ? "R6" : "R5";
        if (op == 4)   return simd ? "R8" : "R7";
        if (op == 5)   return "R9";
        if (op <= 11)  return "R10";
        return "R11";
    endfunction

    task automatic compare();
        n_chk++;
        if (out_valid !== exp_v) begin
            n_bad++;
            $display("FAIL R1 valid: got %0b expected %0b", out_valid, exp_v);
        end
        n_chk++;
        if (out_result !== exp_r) begin
            n_bad++;
            $display("FAIL %s result: got %08h expected %08h", exp_tag, out_result, exp_r);
        end
    endtask

    task automatic step(input logic v, input logic [3:0] op, input logic simd,
                        input logic [31:0] a, input logic [31:0] b);
        in_valid = v; in_op = op; in_simd = simd; in_a = a; in_b = b;
        @(negedge clk);
        exp_v = v;
        if (v) begin
            exp_r   = ref_model(op, simd, a, b);
            exp_tag = tag_of(op, simd);
        end else begin
            exp_tag = "R2";
        end
        compare();
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20ns * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(); // R2 reset state
        rst_n = 1'b1;
        // R3 word shifts, including amount 0, 31 and ignored upper bits of b
        step(1, 4'd0, 0, 32'h8000_0001, 32'hFFFF_FFE1);
        step(1, 4'd0, 0, 32'h1234_5678, 32'h0);
        step(1, 4'd1, 0, 32'h8000_0000, 32'd31);
        step(1, 4'd2, 0, 32'h8000_0000, 32'd31);
        step(1, 4'd2, 0, 32'h7F00_0000, 32'd4);
        // R2 hold while idle
        step(0, 4'd5, 0, 32'hDEAD_BEEF, 32'hCAFE_F00D);
        step(0, 4'd0, 0, 32'h0, 32'h0);
        // R4 lanes: no crossing, sign from bit 15 and bit 31
        step(1, 4'd0, 1, 32'h0000_8001, 32'h0001_0001);
        step(1, 4'd1, 1, 32'h0001_0000, 32'h0003_0001);
        step(1, 4'd2, 1, 32'h4000_8000, 32'h000F_000F);
        step(1, 4'd2, 1, 32'h8000_7FFF, 32'h0004_0004);
        // R5 / R6 extract
        step(1, 4'd3, 0, 32'hA5A5_F00F, {22'h0, 5'd31, 5'd0});
        step(1, 4'd3, 0, 32'hF000_0000, {22'h0, 5'd7, 5'd28});
        step(1, 4'd3, 1, 32'hABCD_1234, 32'h0037_0034);
        // R7 / R8 deposit, including truncation at the top
        step(1, 4'd4, 0, 32'h0000_0000, {16'hFFFF, 6'h0, 5'd7, 5'd28});
        step(1, 4'd4, 0, 32'hFFFF_FFFF, {16'h0000, 6'h0, 5'd3, 5'd8});
        step(1, 4'd4, 1, 32'h0000_0000, 32'hFF7C_FF7C);
        step(1, 4'd4, 1, 32'h1234_5678, 32'h5A34_A504);
        // R9 pack, SIMD flag ignored
        step(1, 4'd5, 1, 32'h1111_2222, 32'h3333_4444);
        // R10 unpack
        for (int op = 6; op <= 11; op++) step(1, 4'(op), op[0], 32'h8081_F0F0, 32'h0);
        // R11 undefined
        for (int op = 12; op <= 15; op++) step(1, 4'(op), 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        // mixed traffic with idle gaps
        for (int k = 0; k < 3000; k++)
            step(($urandom % 5) != 0, 4'($urandom), 1'($urandom), $urandom, $urandom);
        step(0, 4'd0, 0, 32'h0, 32'h0);
        finish_run();
    end

endmodule